// File: doc/BRIEF.md
# Narrow-Port Staging Mailbox Registers

This block is the device side of a staging mailbox. A host reaches it through a 32-bit memory-mapped slave port with single-cycle read and write strobes. The port has four registers: control, status, send-stream and receive-stream. Each data direction has one fixed address. Repeated writes to the send-stream address build a request in a buffer, and repeated accesses to the receive-stream address walk through a response buffer. No per-word address is needed.

When the host sets the start bit in control, the collected request is handed to a processing engine. The engine reads the request through an indexed port, loads response words, and finishes with a done or error indication. These set the status bits that the host polls. A receive-stream word is consumed only when the host writes to the receive-stream address. A read on its own never consumes a word, so the host reads the word first and then acknowledges it.

Top module: `mbx_stream_regs`

## Requirements
- R1: The byte address map is control 0x0, status 0x4, send-stream 0x8 and receive-stream 0xC. After reset, status reads 0, receive-stream reads 0 and the request word count is 0.
- R2: Each write to 0x8 appends its data to the request in arrival order. `eng_req_count` gives the number of stored words. `eng_req_data` returns the word at index `eng_req_idx`, where 0 is the first word written.
- R3: A read of 0xC returns the head word of the response and does not advance it. Repeated reads return the same word.
- R4: A write of any value to 0xC acknowledges the head word, and the next read returns the following word in load order.
- R5: Reading 0xC while the response is empty returns 0. A write to 0xC while it is empty has no effect.
- R6: A control write with bit 31 set and bit 0 clear, while no transaction is in flight, starts a transaction. `eng_go` is high for exactly one cycle, status bits 31 and 2 read 0 afterwards, and the previous response is discarded.
- R7: While a transaction is in flight, `eng_done` sets status bit 31 (ready) and `eng_err` sets status bit 2 (error). Either of them ends the transaction. Both are ignored when no transaction is in flight.
- R8: While a transaction is in flight, a further start write produces no `eng_go` pulse, and writes to 0x8 leave the request unchanged.
- R9: A control write with bit 0 set is an abort, and it takes priority over bit 31. It empties the request and the response, clears status and any transaction in flight, and pulses `eng_abort` for one cycle with no `eng_go` pulse.
- R10: Writes to 0x8 beyond REQ_DEPTH words are dropped and set status bit 2. That flag holds through a start and clears only on abort or at the end of the transaction.
- R11: The request count returns to 0 when a transaction ends through done or error.
- R12: Response words loaded beyond RSP_DEPTH are dropped. Response words are only accepted while a transaction is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is 0 when this is low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| eng_go | output | 1 | One-cycle start pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| eng_req_count | output | REQ_CW | Number of request words stored |
| eng_req_idx | input | REQ_IW | Request word index to read |
| eng_req_data | output | 32 | Request word at `eng_req_idx` |
| eng_rsp_we | input | 1 | Load one response word |
| eng_rsp_data | input | 32 | Response word to load |
| eng_done | input | 1 | Transaction completed successfully |
| eng_err | input | 1 | Transaction failed |

## Verification
The assertions check properties that must hold on every cycle:
- the request count never exceeds its depth;
- a write to a full request leaves the count unchanged;
- the response count changes only on a load, an acknowledge or a clear;
- an acknowledge of an empty response keeps it empty;
- a start pulse always coincides with cleared ready and error;
- a start write while busy is never forwarded;
- an abort pulse is accompanied by empty buffers.

Only the bench's scenarios can show the rest. These are the ordering of stored and returned words across every request length up to and past the depth, the fact that repeated reads do not consume a word, the zero returned when the response is empty, and how the overflow flag carries through a start and clears when the transaction ends.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   localparam logic [3:0] OFF_CTRL  = 4'h0;
   localparam logic [3:0] OFF_STAT  = 4'h4;
   localparam logic [3:0] OFF_SEND  = 4'h8;
   localparam logic [3:0] OFF_RECV  = 4'hC;

   localparam int unsigned CTRL_START_BIT = 31;
   localparam int unsigned CTRL_ABORT_BIT = 0;
   localparam int unsigned STAT_READY_BIT = 31;
   localparam int unsigned STAT_ERROR_BIT = 2;
endpackage

// File: rtl/mbx_req_buf.sv
module mbx_req_buf #(
   parameter int unsigned DEPTH = 1028,
   parameter int unsigned DW    = 32,
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          dropped,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 5) begin : g_bad_depth
         $error("mbx_req_buf: DEPTH must hold at least the header words");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic          full;

   assign full    = (count == CW'(DEPTH));
   assign dropped = wr_en && full && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (wr_en && !full) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !full && !clr) begin
         mem[IW'(count)] <= wr_data;
      end
   end

   assign rd_data = (32'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/mbx_rsp_buf.sv
module mbx_rsp_buf #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 32,
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mbx_rsp_buf: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && (count != '0);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) begin
         mem[wr_ptr] <= push_data;
      end
   end

   assign head = (count != '0) ? mem[rd_ptr] : '0;

   a_r3_hold_without_op: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop && !clr) |=> (count == $past(count)));

   a_r5_empty_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && (count == '0) && !push && !clr) |=> (count == '0));

   a_r12_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/mbx_stream_regs.sv
module mbx_stream_regs #(
   parameter int unsigned REQ_DEPTH = 1028,
   parameter int unsigned RSP_DEPTH = 16,
   parameter int unsigned ADDR_W    = 4,
   localparam int unsigned REQ_CW   = $clog2(REQ_DEPTH + 1),
   localparam int unsigned REQ_IW   = (REQ_DEPTH > 1) ? $clog2(REQ_DEPTH) : 1,
   localparam int unsigned RSP_CW   = $clog2(RSP_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 eng_go,
   output logic                 eng_abort,
   output logic [REQ_CW-1:0]    eng_req_count,
   input  logic [REQ_IW-1:0]    eng_req_idx,
   output logic [31:0]          eng_req_data,
   input  logic                 eng_rsp_we,
   input  logic [31:0]          eng_rsp_data,
   input  logic                 eng_done,
   input  logic                 eng_err
);
   import mbx_pkg::*;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("mbx_stream_regs: ADDR_W must cover four word registers");
      end
   endgenerate

   logic [3:0]        reg_off;
   logic              hi_zero;
   logic              wr_ctl, wr_send, wr_recv;
   logic              abort_req, start_req, start_ok, finish;
   logic              busy_q, ready_q, eerr_q, ovf_q;
   logic              req_drop;
   word_t             rsp_head;
   logic [RSP_CW-1:0] rsp_count;
   word_t             stat_word;

   assign reg_off = bus_addr[3:0];
   generate
      if (ADDR_W > 4) begin : g_hi_dec
         assign hi_zero = (bus_addr[ADDR_W-1:4] == '0);
      end else begin : g_no_hi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign wr_ctl  = bus_wr && hi_zero && (reg_off == OFF_CTRL);
   assign wr_send = bus_wr && hi_zero && (reg_off == OFF_SEND);
   assign wr_recv = bus_wr && hi_zero && (reg_off == OFF_RECV);

   assign abort_req = wr_ctl && bus_wdata[CTRL_ABORT_BIT];
   assign start_req = wr_ctl && bus_wdata[CTRL_START_BIT] && !bus_wdata[CTRL_ABORT_BIT];
   assign start_ok  = start_req && !busy_q;
   assign finish    = busy_q && (eng_done || eng_err) && !abort_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         ready_q   <= 1'b0;
         eerr_q    <= 1'b0;
         ovf_q     <= 1'b0;
         eng_go    <= 1'b0;
         eng_abort <= 1'b0;
      end else begin
         eng_go    <= start_ok;
         eng_abort <= abort_req;
         if (abort_req) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
            eerr_q  <= 1'b0;
            ovf_q   <= 1'b0;
         end else begin
            if (start_ok) begin
               busy_q  <= 1'b1;
               ready_q <= 1'b0;
               eerr_q  <= 1'b0;
            end else if (finish) begin
               busy_q  <= 1'b0;
               ready_q <= eng_done;
               eerr_q  <= eng_err;
            end
            if (finish)        ovf_q <= 1'b0;
            else if (req_drop) ovf_q <= 1'b1;
         end
      end
   end

   mbx_req_buf #(.DEPTH(REQ_DEPTH), .DW(WORD_W)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (abort_req || finish),
      .wr_en   (wr_send && !busy_q),
      .wr_data (bus_wdata),
      .dropped (req_drop),
      .rd_idx  (eng_req_idx),
      .rd_data (eng_req_data),
      .count   (eng_req_count)
   );

   mbx_rsp_buf #(.DEPTH(RSP_DEPTH), .DW(WORD_W)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (abort_req || start_ok),
      .push      (eng_rsp_we && busy_q),
      .push_data (eng_rsp_data),
      .pop       (wr_recv),
      .head      (rsp_head),
      .count     (rsp_count)
   );

   always_comb begin
      stat_word                 = '0;
      stat_word[STAT_READY_BIT] = ready_q;
      stat_word[STAT_ERROR_BIT] = eerr_q || ovf_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && hi_zero) begin
         case (reg_off)
            OFF_STAT: bus_rdata = stat_word;
            OFF_RECV: bus_rdata = rsp_head;
            default:  bus_rdata = '0;
         endcase
      end
   end

   a_r6_go_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> (!ready_q && !eerr_q && busy_q));

   a_r8_no_go_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && busy_q) |=> !eng_go);

   a_r9_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |-> ((eng_req_count == '0) && (rsp_count == '0) && !busy_q && !eng_go));

   a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |-> !busy_q);
endmodule

// File: tb/mbx_stream_regs_bench.sv
module mbx_stream_regs_bench;
   localparam int unsigned RD = 8;
   localparam int unsigned SD = 3;
   localparam int unsigned CW = $clog2(RD + 1);
   localparam int unsigned IW = $clog2(RD);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          eng_go, eng_abort;
   logic [CW-1:0] eng_req_count;
   logic [IW-1:0] eng_req_idx = '0;
   logic [31:0]   eng_req_data;
   logic          eng_rsp_we = 1'b0;
   logic [31:0]   eng_rsp_data = '0;
   logic          eng_done = 1'b0, eng_err = 1'b0;

   int n_chk = 0, n_fail = 0, go_cnt = 0, abort_cnt = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mbx_stream_regs #(.REQ_DEPTH(RD), .RSP_DEPTH(SD), .ADDR_W(4)) u_mbx_stream_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_go(eng_go), .eng_abort(eng_abort),
      .eng_req_count(eng_req_count), .eng_req_idx(eng_req_idx), .eng_req_data(eng_req_data),
      .eng_rsp_we(eng_rsp_we), .eng_rsp_data(eng_rsp_data), .eng_done(eng_done), .eng_err(eng_err)
   );

   always @(negedge clk) begin
      if (eng_go)    go_cnt++;
      if (eng_abort) abort_cnt++;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bwr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic push(logic [31:0] d);
      @(negedge clk);
      eng_rsp_we = 1'b1; eng_rsp_data = d;
      @(negedge clk);
      eng_rsp_we = 1'b0;
   endtask

   task automatic fin(bit dn, bit er);
      @(negedge clk);
      eng_done = dn; eng_err = er;
      @(negedge clk);
      eng_done = 1'b0; eng_err = 1'b0;
   endtask

   task automatic req_word(int i, output logic [31:0] d);
      @(negedge clk);
      eng_req_idx = IW'(i);
      #1 d = eng_req_data;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int g0, a0, nk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      brd(4'h4, v); chk("R1 status after reset", v, 32'h0);
      brd(4'hC, v); chk("R1 recv after reset", v, 32'h0);
      chk("R1 count after reset", 32'(eng_req_count), 32'h0);

      // R2 / R10: sweep request lengths through and past the depth
      for (int n = 0; n <= RD + 2; n++) begin
         bwr(4'h0, 32'h1);
         for (int i = 0; i < n; i++) bwr(4'h8, 32'hA000_0000 + 32'(n * 16 + i));
         @(negedge clk);
         nk = (n > RD) ? RD : n;
         chk("R2 request count", 32'(eng_req_count), 32'(nk));
         for (int i = 0; i < nk; i++) begin
            req_word(i, v);
            chk("R2 request order", v, 32'hA000_0000 + 32'(n * 16 + i));
         end
         brd(4'h4, v);
         chk("R10 overflow error bit", v, (n > RD) ? 32'h4 : 32'h0);
      end

      // R10: overflow flag survives start, clears at transaction end
      g0 = go_cnt;
      bwr(4'h0, 32'h8000_0000);
      brd(4'h4, v); chk("R10 overflow kept after start", v, 32'h4);
      fin(1'b1, 1'b0);
      brd(4'h4, v); chk("R10 overflow cleared at end", v, 32'h8000_0000);
      chk("R11 count zero after done", 32'(eng_req_count), 32'h0);

      // R3 R4 R5 R6 R8 R12: sweep response lengths
      for (int k = 0; k <= SD + 1; k++) begin
         bwr(4'h0, 32'h1);
         for (int i = 0; i < 3; i++) bwr(4'h8, 32'h5000 + 32'(i));
         g0 = go_cnt;
         bwr(4'h0, 32'h8000_0000);
         @(negedge clk);
         chk("R6 one go pulse", 32'(go_cnt - g0), 32'h1);
         brd(4'h4, v); chk("R6 status cleared on start", v, 32'h0);
         bwr(4'h8, 32'hDEAD);
         chk("R8 send ignored while busy", 32'(eng_req_count), 32'h3);
         bwr(4'h0, 32'h8000_0000);
         @(negedge clk);
         chk("R8 start ignored while busy", 32'(go_cnt - g0), 32'h1);
         for (int i = 0; i < k; i++) push(32'hC000_0000 + 32'(k * 16 + i));
         fin(1'b1, 1'b0);
         brd(4'h4, v); chk("R7 ready after done", v, 32'h8000_0000);
         chk("R11 request cleared", 32'(eng_req_count), 32'h0);
         nk = (k > SD) ? SD : k;
         for (int i = 0; i < nk; i++) begin
            brd(4'hC, v); chk("R3 head word", v, 32'hC000_0000 + 32'(k * 16 + i));
            brd(4'hC, v); chk("R3 read does not advance", v, 32'hC000_0000 + 32'(k * 16 + i));
            bwr(4'hC, 32'h0);
         end
         brd(4'hC, v); chk("R12 R5 empty after drain", v, 32'h0);
         bwr(4'hC, 32'h0);
         brd(4'hC, v); chk("R5 ack on empty", v, 32'h0);
      end

      // R4: acknowledge with nonzero value; R6: start discards old response
      bwr(4'h0, 32'h8000_0000);
      push(32'h11); push(32'h22);
      fin(1'b1, 1'b0);
      bwr(4'hC, 32'hFFFF_FFFF);
      brd(4'hC, v); chk("R4 any value advances", v, 32'h22);
      bwr(4'h0, 32'h8000_0000);
      brd(4'hC, v); chk("R6 response discarded on start", v, 32'h0);
      brd(4'h4, v); chk("R6 ready cleared on start", v, 32'h0);

      // R7: error ends transaction
      fin(1'b0, 1'b1);
      brd(4'h4, v); chk("R7 error bit", v, 32'h4);
      fin(1'b1, 1'b0);
      brd(4'h4, v); chk("R7 done ignored when idle", v, 32'h4);

      // R12: response load while idle is dropped
      push(32'h77);
      brd(4'hC, v); chk("R12 load while idle dropped", v, 32'h0);

      // R9: abort wins over start
      bwr(4'h8, 32'h9);
      g0 = go_cnt; a0 = abort_cnt;
      bwr(4'h0, 32'h8000_0001);
      @(negedge clk);
      chk("R9 no go on abort", 32'(go_cnt - g0), 32'h0);
      chk("R9 abort pulse", 32'(abort_cnt - a0), 32'h1);
      chk("R9 request emptied", 32'(eng_req_count), 32'h0);
      brd(4'h4, v); chk("R9 status cleared", v, 32'h0);

      // R9: abort mid-transaction
      bwr(4'h8, 32'h1);
      bwr(4'h0, 32'h8000_0000);
      push(32'h33);
      bwr(4'h0, 32'h1);
      brd(4'hC, v); chk("R9 response emptied", v, 32'h0);
      fin(1'b1, 1'b0);
      brd(4'h4, v); chk("R9 idle after abort", v, 32'h0);
      brd(4'h0, v); chk("R1 control reads zero", v, 32'h0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule